// File: doc/BRIEF.md
# Display Event Interrupt Register

This block is the shared interrupt register of a display controller that drives two panel channels, a main one and a sub one. Each channel reports three kinds of timing event as single-cycle pulses: the end of vertical sync, the start of vertical sync, and a frame boundary. The block latches each kind of event in a status bit. It holds a matching enable bit for each status bit in the same 32-bit word. It raises one interrupt line whenever an enabled status bit is set.

Software reads the word to see which events are pending. It acknowledges them by writing the word back with zeros in the status bits it has serviced. The same write sets the enable bits, so a handler can drop the vertical-sync-end enable once a pending pan update has been applied. A second, read-only status register reports which channel produced the most recently latched event. This lets one handler serve both channels.

Top module: `dpirq_ctrl`

## Requirements
- R1: After reset the interrupt word reads 0, the source register reads 0 and `irq` is low; while all enable bits are 0, `irq` stays low.
- R2: A pulse on an event input of any channel sets its status bit in the interrupt word one cycle later, whether or not the matching enable is set. Status bit 0 is vsync-end, bit 1 is vsync-start and bit 2 is the frame event.
- R3: A write to the interrupt word (address 0) clears each status bit whose written value is 0 and leaves unchanged each status bit whose written value is 1.
- R4: When an event arrives in the same cycle as a write that clears its status bit, the event wins and the bit reads 1 afterwards.
- R5: Enable bits sit at bit 8 (vsync-end), bit 9 (vsync-start) and bit 10 (frame event). Every write to address 0 loads all three from the written data, and they read back at the same positions.
- R6: `irq` is high exactly when some status bit and its enable (status bit k paired with enable bit k+8) are both 1. Enabling a bit whose status is already pending raises `irq` in the cycle after the write.
- R7: Source register (address 1) bit 10 reads 1 when the most recently latched event came from the sub channel (index 1) and 0 when it came from the main channel (index 0). It holds between events. When both channels pulse in the same cycle, the sub channel is recorded.
- R8: Bits 3 to 7 and 11 to 31 of the interrupt word, and all bits of the source register except bit 10, read 0. Writes to the source register or to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address: 0 interrupt word, 1 source register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_vend | input | 2 | Vsync-end pulse, one bit per channel |
| ev_vstart | input | 2 | Vsync-start pulse, one bit per channel |
| ev_frame | input | 2 | Frame event pulse, one bit per channel |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an event that lands on the exact clock edge where software's acknowledge write clears the same bit. The bench drives the write strobe and the event pulse in the same half-cycle window, so both are sampled at one edge. It then expects the bit to survive and the interrupt to stay high. A second delicate case is two channels pulsing together. The bench pulses both at once and then the main channel alone, to see the source bit move from 1 to 0.

// File: rtl/dpirq_pkg.sv
package dpirq_pkg;
   localparam int NUM_EVT   = 3;
   localparam int EN_OFS    = 8;
   localparam int CLR_MSB   = 6;
   localparam int SRC_LSB   = 10;
   localparam int INT_WORD  = 0;
   localparam int SRC_WORD  = 1;

   typedef enum logic [1:0] {
      EVK_VEND   = 2'd0,
      EVK_VSTART = 2'd1,
      EVK_FRAME  = 2'd2
   } evt_kind_e;
endpackage

// File: rtl/dpirq_evt_merge.sv
module dpirq_evt_merge #(
   parameter int NCH   = 2,
   parameter int SRC_W = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   ev_vend,
   input  logic [NCH-1:0]   ev_vstart,
   input  logic [NCH-1:0]   ev_frame,
   output logic [2:0]       hit,
   output logic [SRC_W-1:0] src_q
);
   logic [NCH-1:0]   chan_any;
   logic [SRC_W-1:0] src_d;

   assign hit[dpirq_pkg::EVK_VEND]   = |ev_vend;
   assign hit[dpirq_pkg::EVK_VSTART] = |ev_vstart;
   assign hit[dpirq_pkg::EVK_FRAME]  = |ev_frame;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      assign chan_any[c] = ev_vend[c] | ev_vstart[c] | ev_frame[c];
   end

   always_comb begin
      src_d = src_q;
      for (int i = 0; i < NCH; i++) begin
         if (chan_any[i]) src_d = SRC_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_d;
   end

   // R7
   src_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_any[NCH-1] |=> (src_q == SRC_W'(NCH-1)));
   // R7
   src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_any == '0) |=> $stable(src_q));
endmodule

// File: rtl/dpirq_stat_cell.sv
module dpirq_stat_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wr_i,
   input  logic keep_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (set_i) q <= 1'b1;
      else if (wr_i)  q <= q & keep_i;
   end

   // R2
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q);
   // R3
   zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !keep_i && !set_i) |=> !q);
   // R3
   one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && keep_i && !set_i) |=> (q == $past(q)));
endmodule

// File: rtl/dpirq_rd_mux.sv
module dpirq_rd_mux #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int SRC_W  = 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        stat,
   input  logic [2:0]        en,
   input  logic [SRC_W-1:0]  src,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] int_word;
   logic [DATA_W-1:0] src_word;

   always_comb begin
      int_word = '0;
      int_word[dpirq_pkg::NUM_EVT-1:0] = stat;
      int_word[dpirq_pkg::EN_OFS +: dpirq_pkg::NUM_EVT] = en;
      src_word = '0;
      src_word[dpirq_pkg::SRC_LSB +: SRC_W] = src;
      if (addr == ADDR_W'(dpirq_pkg::INT_WORD))      rdata = int_word;
      else if (addr == ADDR_W'(dpirq_pkg::SRC_WORD)) rdata = src_word;
      else                                           rdata = '0;
   end
endmodule

// File: rtl/dpirq_ctrl.sv
module dpirq_ctrl #(
   parameter int NCH    = 2,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NCH-1:0]    ev_vend,
   input  logic [NCH-1:0]    ev_vstart,
   input  logic [NCH-1:0]    ev_frame,
   output logic              irq
);
   import dpirq_pkg::*;

   localparam int SRC_W = (NCH > 1) ? $clog2(NCH) : 1;

   if (NCH < 2) begin : g_bad_nch
      $error("dpirq_ctrl: NCH must be at least 2");
   end
   if (DATA_W < SRC_LSB + SRC_W) begin : g_bad_dw
      $error("dpirq_ctrl: DATA_W too narrow for the source field");
   end
   if (ADDR_W < 1) begin : g_bad_aw
      $error("dpirq_ctrl: ADDR_W must be at least 1");
   end

   logic [2:0]       hit;
   logic [SRC_W-1:0] src_q;
   logic [2:0]       stat_q;
   logic [2:0]       en_q;
   logic             int_wr;
   logic             unused_wdata;

   assign int_wr       = reg_wr && (reg_addr == ADDR_W'(INT_WORD));
   assign unused_wdata = ^reg_wdata;

   dpirq_evt_merge #(.NCH(NCH), .SRC_W(SRC_W)) merge_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_vend   (ev_vend),
      .ev_vstart (ev_vstart),
      .ev_frame  (ev_frame),
      .hit       (hit),
      .src_q     (src_q)
   );

   for (genvar k = 0; k < NUM_EVT; k++) begin : g_stat
      dpirq_stat_cell cell_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (hit[k]),
         .wr_i   (int_wr),
         .keep_i (reg_wdata[k]),
         .q      (stat_q[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (int_wr) en_q <= reg_wdata[EN_OFS +: NUM_EVT];
   end

   assign irq = |(stat_q & en_q);

   dpirq_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_W(SRC_W)) rd_i (
      .addr  (reg_addr),
      .stat  (stat_q),
      .en    (en_q),
      .src   (src_q),
      .rdata (reg_rdata)
   );

   // R5
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_wr |=> (en_q == $past(reg_wdata[EN_OFS +: NUM_EVT])));
   // R5
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !int_wr |=> $stable(en_q));
   // R6
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(int_wr || (hit != 3'b000)));
   // R1
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == 3'b000) |-> !irq);
endmodule

// File: tb/dpirq_ctrl_tb.sv
module dpirq_ctrl_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  ev_vend = '0;
   logic [1:0]  ev_vstart = '0;
   logic [1:0]  ev_frame = '0;
   logic        irq;

   int total = 0;
   int bad = 0;

   dpirq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_vend(ev_vend),
      .ev_vstart(ev_vstart), .ev_frame(ev_frame), .irq(irq)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic pulse(input logic [1:0] v, input logic [1:0] s, input logic [1:0] f);
      @(negedge clk);
      ev_vend = v; ev_vstart = s; ev_frame = f;
      @(negedge clk);
      ev_vend = '0; ev_vstart = '0; ev_frame = '0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(4'd0, d); chk("R1 int word", d, 32'h0);
      rd(4'd1, d); chk("R1 source", d, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_latch;
      logic [31:0] d;
      pulse(2'b01, 2'b00, 2'b00);
      rd(4'd0, d); chk("R2 vend bit0", d, 32'h1);
      chk("R1 irq masked", {31'b0, irq}, 32'h0);
      pulse(2'b00, 2'b10, 2'b00);
      rd(4'd0, d); chk("R2 vstart bit1", d, 32'h3);
      rd(4'd1, d); chk("R7 sub source", d, 32'h400);
      pulse(2'b00, 2'b00, 2'b01);
      rd(4'd0, d); chk("R2 frame bit2", d, 32'h7);
      rd(4'd1, d); chk("R7 main source", d, 32'h0);
   endtask

   task automatic t_clear;
      logic [31:0] d;
      wr(4'd0, 32'h5);
      rd(4'd0, d); chk("R3 clear bit1 only", d, 32'h5);
      rd(4'd1, d); chk("R7 held on write", d, 32'h0);
      wr(4'd0, 32'h0);
      rd(4'd0, d); chk("R3 clear all", d, 32'h0);
   endtask

   task automatic t_enable;
      logic [31:0] d;
      pulse(2'b00, 2'b00, 2'b10);
      rd(4'd0, d); chk("R2 frame latched masked", d, 32'h4);
      chk("R6 irq low masked", {31'b0, irq}, 32'h0);
      wr(4'd0, 32'h404);
      chk("R6 irq on enable", {31'b0, irq}, 32'h1);
      rd(4'd0, d); chk("R5 enable readback", d, 32'h404);
      wr(4'd0, 32'h400);
      chk("R6 irq after ack", {31'b0, irq}, 32'h0);
      rd(4'd0, d); chk("R3 ack keeps enable", d, 32'h400);
      wr(4'd0, 32'h700);
      rd(4'd0, d); chk("R5 all enables", d, 32'h700);
   endtask

   task automatic t_race;
      logic [31:0] d;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h100; ev_vend = 2'b01;
      @(negedge clk);
      reg_wr = 1'b0; ev_vend = 2'b00;
      rd(4'd0, d); chk("R4 event beats clear", d, 32'h101);
      chk("R6 irq vend enabled", {31'b0, irq}, 32'h1);
      wr(4'd0, 32'h0);
      chk("R6 irq dropped", {31'b0, irq}, 32'h0);
      rd(4'd0, d); chk("R3 handler ack", d, 32'h0);
   endtask

   task automatic t_source_misc;
      logic [31:0] d;
      pulse(2'b00, 2'b11, 2'b00);
      rd(4'd1, d); chk("R7 simultaneous sub wins", d, 32'h400);
      pulse(2'b01, 2'b00, 2'b00);
      rd(4'd1, d); chk("R7 back to main", d, 32'h0);
      wr(4'd1, 32'hFFFF_FFFF);
      rd(4'd1, d); chk("R8 source write ignored", d, 32'h0);
      rd(4'd0, d); chk("R8 int word untouched", d, 32'h3);
      wr(4'd3, 32'h0);
      rd(4'd0, d); chk("R8 other address ignored", d, 32'h3);
      rd(4'd3, d); chk("R8 other address reads 0", d, 32'h0);
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, d); chk("R8 reserved bits zero", d, 32'h703);
      chk("R6 irq pending enabled", {31'b0, irq}, 32'h1);
   endtask

   initial begin
      #(CLK_P * 100000);
      total++; bad++;
      $display("FAIL watchdog: got=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_latch;
      t_clear;
      t_enable;
      t_race;
      t_source_misc;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule